// File: doc/BRIEF.md
# Parallel ATA Device Protocol Controller

This block sits on the device side of a parallel ATA link and plays the part of one drive. The host reaches it through single-cycle register accesses: byte accesses to the task-file registers, 16-bit accesses to the data register, and byte accesses to the control block, which holds alternate status for reads and device control for writes. The block tracks whether the drive-select bit addresses this device. It keeps the busy, data-request, ready, seek-complete and error status bits. It raises or drops the interrupt request line under control of the interrupt-disable bit, and it runs each command to completion.

Non-data commands finish at once. PIO data-in and data-out commands move one sector of `SECTOR_WORDS` 16-bit words at a time. Sector storage lives outside the block. A sector request stream (valid/ready, with a store flag and a 28-bit LBA) asks the external buffer to fetch or commit a sector. An inbound word stream feeds host data reads, and an outbound word stream carries host data writes. The request stream holds valid and address stable until ready. The two word streams cannot stall the host, which never waits. A data read with `rd_valid` low, or a data write with `wr_ready` low, is lost and raises the sticky error flag. DMA commands hand the transfer to an external engine and wait for its done pulse.

Top module: `ata_dev_ctrl`

## Requirements
- R1: After reset the status byte reads 0x40 (bit7 busy, bit6 ready, bit4 seek complete, bit3 data request, bit0 error), `intrq` is 0 and `err_flag` is 0.
- R2: The device is selected when drive/head register bit 4 equals `DEV_ID`. A command-register write while the device is not selected is ignored: status and `intrq` stay unchanged.
- R3: A non-data command (opcodes 0x10, 0x91, 0xE7, 0x40, 0x70, 0xEF, 0xC6) completes within one cycle with status 0x40. The interrupt is posted when nIEN (device control bit 1) is 0, and the interrupt line rises only when nIEN was 0 in the cycle before.
- R4: Reading the alternate status register (control block, address 6) leaves a pending interrupt in place. Reading the primary status register (command block, address 7) returns status and clears the pending interrupt.
- R5: With nIEN set to 1, commands complete and data becomes ready without raising `intrq`.
- R6: Opcode 0xF8 loads CAPACITY-1 into the address registers: bits 7:0 to address 3, bits 15:8 to address 4, bits 23:16 to address 5, and bits 27:24 to the low nibble of address 6. The high nibble of address 6 is kept.
- R7: A read, write or DMA command issued with drive/head bit 6 clear, or any unknown opcode, is rejected. Status becomes 0x41, the error register (address 1) reads 0x04, and the interrupt follows the R3 rule.
- R8: PIO data-in (0x20, 0xC4) issues one fetch request per sector at an LBA that starts at the task-file address and rises by one per sector. The sector request holds valid and LBA until accepted. Each sector then sets data request, posting the interrupt when nIEN=0. Each 16-bit data read returns the next inbound word. After the last word of the last sector the status returns to 0x40 with no interrupt. Busy and data request are never both set.
- R9: PIO data-out (0x30, 0xC5) sets data request per sector, posting the interrupt when nIEN=0. Each 16-bit data write emits one word on the outbound stream. After a full sector a store request commits it at the running LBA. After the final sector the command completes following the R3 interrupt rule.
- R10: A sector count of 0 transfers 256 sectors.
- R11: Opcode 0xC8 (device to memory, `dma_to_mem`=1) or 0xCA (`dma_to_mem`=0) raises `dma_active` with status 0x48. A `dma_done` pulse completes the command with status 0x50 and the R3 interrupt rule.
- R12: An illegal access sets the sticky `err_flag` and changes no register. Illegal accesses are: a 16-bit access other than at data, a byte access to data, a control-block access other than byte address 6, or a control write with bit 2 (software reset) set.
- R13: Setting nIEN while the device is idle with an interrupt pending clears the interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_stb | input | 1 | Host register access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_ctl | input | 1 | 1 = control block, 0 = command block |
| acc_addr | input | 3 | Register address within the block |
| acc_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data, valid in the strobe cycle |
| intrq | output | 1 | Interrupt request |
| err_flag | output | 1 | Sticky protocol/access error |
| req_valid | output | 1 | Sector request valid |
| req_ready | input | 1 | Sector request accepted |
| req_store | output | 1 | 1 = commit sector, 0 = fetch sector |
| req_lba | output | 28 | Sector address of the request |
| rd_valid | input | 1 | Inbound word available |
| rd_ready | output | 1 | Inbound word consumed by a host data read |
| rd_data | input | 16 | Inbound word |
| wr_valid | output | 1 | Outbound word from a host data write |
| wr_ready | input | 1 | Outbound stream can take a word |
| wr_data | output | 16 | Outbound word |
| dma_active | output | 1 | DMA phase of a DMA command is in progress |
| dma_to_mem | output | 1 | DMA direction, 1 = device to memory |
| dma_done | input | 1 | DMA engine completion pulse |

## Verification
Some rules are checked on every cycle. Busy and data request are never set together. A pending sector request keeps valid and LBA until accepted. Inbound words are consumed only while data request is up. The interrupt rises only after nIEN was clear. The DMA phase never shows busy, and the error flag never falls. Other behaviour only the bench scenarios can show. These are the order of interrupt post and clear around status reads, deselection and nIEN changes, the per-sector LBA progression and word contents on both streams, the 256-sector meaning of a zero count, the read-max address split, and rejection of non-LBA commands.

// File: rtl/ata_dev_pkg.sv
package ata_dev_pkg;

  typedef enum logic [3:0] {
    ST_IDLE_NS,
    ST_IDLE_S,
    ST_IDLE_SI,
    ST_IN_REQ,
    ST_IN_INTR,
    ST_IN_XFER,
    ST_OUT_PREP,
    ST_OUT_INTR,
    ST_OUT_XFER,
    ST_OUT_COMMIT,
    ST_DMA
  } dev_state_e;

  typedef enum logic [2:0] {
    CK_NODATA,
    CK_MAXADDR,
    CK_PIO_IN,
    CK_PIO_OUT,
    CK_DMA_IN,
    CK_DMA_OUT,
    CK_BAD
  } cmd_kind_e;

  typedef struct packed {
    logic stat_rd;
    logic cmd_wr;
    logic data_rd;
    logic data_wr;
    logic ctl_wr;
    logic bad;
  } acc_ev_t;

  localparam logic [2:0] REG_DATA = 3'd0;
  localparam logic [2:0] REG_ERR  = 3'd1;
  localparam logic [2:0] REG_STAT = 3'd7;
  localparam logic [2:0] REG_CTL  = 3'd6;
  localparam int unsigned TF_FIRST = 2;
  localparam int unsigned TF_LAST  = 6;
  localparam int unsigned CTL_NIEN = 1;
  localparam int unsigned CTL_SRST = 2;
  localparam int unsigned DRV_DEV  = 4;
  localparam int unsigned DRV_LBA  = 6;

  function automatic cmd_kind_e classify(input logic [7:0] op);
    case (op)
      8'h10, 8'h91, 8'hE7, 8'h40, 8'h70, 8'hEF, 8'hC6: classify = CK_NODATA;
      8'hF8:        classify = CK_MAXADDR;
      8'h20, 8'hC4: classify = CK_PIO_IN;
      8'h30, 8'hC5: classify = CK_PIO_OUT;
      8'hC8:        classify = CK_DMA_IN;
      8'hCA:        classify = CK_DMA_OUT;
      default:      classify = CK_BAD;
    endcase
  endfunction

endpackage

// File: rtl/ata_taskfile.sv
module ata_taskfile
  import ata_dev_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_stb,
  input  logic        acc_wr,
  input  logic        acc_ctl,
  input  logic [2:0]  acc_addr,
  input  logic        acc_wide,
  input  logic [7:0]  acc_wbyte,
  input  logic        load_max,
  input  logic [27:0] max_lba,
  output acc_ev_t     ev,
  output logic [7:0]  sec_cnt,
  output logic [7:0]  lba_lo,
  output logic [7:0]  lba_mid,
  output logic [7:0]  lba_hi,
  output logic [7:0]  drive,
  output logic        nien
);

  logic cmd_blk, ctl_blk, is_data, byte_wr;
  logic [7:0] tf_w   [TF_FIRST:TF_LAST];
  logic [7:0] max_by [TF_FIRST:TF_LAST];

  assign cmd_blk = acc_stb & ~acc_ctl;
  assign ctl_blk = acc_stb & acc_ctl;
  assign is_data = (acc_addr == REG_DATA);
  assign byte_wr = cmd_blk & acc_wr & ~acc_wide & ~is_data;

  always_comb begin
    ev.data_rd = cmd_blk & is_data & acc_wide & ~acc_wr;
    ev.data_wr = cmd_blk & is_data & acc_wide & acc_wr;
    ev.stat_rd = cmd_blk & ~acc_wide & ~acc_wr & (acc_addr == REG_STAT);
    ev.cmd_wr  = cmd_blk & ~acc_wide & acc_wr & (acc_addr == REG_STAT);
    ev.ctl_wr  = ctl_blk & acc_wr & ~acc_wide & (acc_addr == REG_CTL) & ~acc_wbyte[CTL_SRST];
    ev.bad     = (cmd_blk & (acc_wide != is_data)) |
                 (ctl_blk & (acc_wide | (acc_addr != REG_CTL) | (acc_wr & acc_wbyte[CTL_SRST])));
  end

  always_comb begin
    max_by[2] = tf_w[2];
    max_by[3] = max_lba[7:0];
    max_by[4] = max_lba[15:8];
    max_by[5] = max_lba[23:16];
    max_by[6] = {tf_w[6][7:4], max_lba[27:24]};
  end

  for (genvar g = TF_FIRST; g <= TF_LAST; g++) begin : g_tf
    logic [7:0] r_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        r_q <= '0;
      else if (load_max)
        r_q <= max_by[g];
      else if (byte_wr && acc_addr == 3'(g))
        r_q <= acc_wbyte;
    end
    assign tf_w[g] = r_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      nien <= 1'b0;
    else if (ev.ctl_wr)
      nien <= acc_wbyte[CTL_NIEN];
  end

  assign sec_cnt = tf_w[2];
  assign lba_lo  = tf_w[3];
  assign lba_mid = tf_w[4];
  assign lba_hi  = tf_w[5];
  assign drive   = tf_w[6];

endmodule

// File: rtl/ata_xfer_count.sv
module ata_xfer_count #(
  parameter int unsigned SECTOR_WORDS = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [7:0]  sec_cnt,
  input  logic [27:0] lba_start,
  input  logic        arm,
  input  logic        step,
  input  logic        lba_step,
  output logic [27:0] lba_cur,
  output logic        drq_last,
  output logic        cmd_last,
  output logic        cmd_empty
);

  localparam int unsigned DRQ_W   = $clog2(SECTOR_WORDS + 1);
  localparam int unsigned CMD_MAX = 256 * SECTOR_WORDS;
  localparam int unsigned CMD_W   = $clog2(CMD_MAX + 1);

  logic [DRQ_W-1:0] drq_q;
  logic [CMD_W-1:0] cmd_q;
  logic [8:0]       sectors;

  assign sectors = (sec_cnt == 8'd0) ? 9'd256 : {1'b0, sec_cnt};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drq_q   <= '0;
      cmd_q   <= '0;
      lba_cur <= '0;
    end else begin
      if (load) begin
        cmd_q   <= CMD_W'(sectors) * CMD_W'(SECTOR_WORDS);
        lba_cur <= lba_start;
      end else begin
        if (step)     cmd_q   <= cmd_q - 1'b1;
        if (lba_step) lba_cur <= lba_cur + 28'd1;
      end
      if (arm)       drq_q <= DRQ_W'(SECTOR_WORDS);
      else if (step) drq_q <= drq_q - 1'b1;
    end
  end

  assign drq_last  = (drq_q == DRQ_W'(1));
  assign cmd_last  = (cmd_q == CMD_W'(1));
  assign cmd_empty = (cmd_q == '0);

endmodule

// File: rtl/ata_intr_ctl.sv
module ata_intr_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic post,
  input  logic clr,
  output logic pend,
  output logic misuse
);

  always_comb begin
    case ({post, clr})
      2'b10:   misuse = pend;
      2'b01:   misuse = ~pend;
      2'b11:   misuse = ~pend;
      default: misuse = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      pend <= 1'b0;
    else if (!misuse) begin
      if (post)     pend <= 1'b1;
      else if (clr) pend <= 1'b0;
    end
  end

endmodule

// File: rtl/ata_dev_ctrl.sv
module ata_dev_ctrl
  import ata_dev_pkg::*;
#(
  parameter int unsigned SECTOR_WORDS = 256,
  parameter logic [27:0] CAPACITY     = 28'h0100000,
  parameter bit          DEV_ID       = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_stb,
  input  logic        acc_wr,
  input  logic        acc_ctl,
  input  logic [2:0]  acc_addr,
  input  logic        acc_wide,
  input  logic [15:0] acc_wdata,
  output logic [15:0] acc_rdata,
  output logic        intrq,
  output logic        err_flag,
  output logic        req_valid,
  input  logic        req_ready,
  output logic        req_store,
  output logic [27:0] req_lba,
  input  logic        rd_valid,
  output logic        rd_ready,
  input  logic [15:0] rd_data,
  output logic        wr_valid,
  input  logic        wr_ready,
  output logic [15:0] wr_data,
  output logic        dma_active,
  output logic        dma_to_mem,
  input  logic        dma_done
);

  localparam logic [27:0] MAX_LBA = CAPACITY - 28'd1;

  acc_ev_t    ev;
  dev_state_e st_q, st_d;
  logic [7:0] sec_cnt, lba_lo, lba_mid, lba_hi, drive, status;
  logic       nien, selected;
  logic       bsy_q, drq_q, serr_q, dsc_q, dir_q;
  logic       bsy_d, drq_d, serr_d, dsc_d, dir_d;
  logic       post, clr, fin, load_cmd, arm, step, lba_step, load_max, miss;
  logic       pend, misuse, drq_last, cmd_last, cmd_empty;
  logic [27:0] lba_cur;
  cmd_kind_e  kind;

  ata_taskfile i_tf (
    .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .acc_wr(acc_wr), .acc_ctl(acc_ctl),
    .acc_addr(acc_addr), .acc_wide(acc_wide), .acc_wbyte(acc_wdata[7:0]),
    .load_max(load_max), .max_lba(MAX_LBA), .ev(ev), .sec_cnt(sec_cnt),
    .lba_lo(lba_lo), .lba_mid(lba_mid), .lba_hi(lba_hi), .drive(drive), .nien(nien)
  );

  ata_xfer_count #(.SECTOR_WORDS(SECTOR_WORDS)) i_cnt (
    .clk(clk), .rst_n(rst_n), .load(load_cmd), .sec_cnt(sec_cnt),
    .lba_start({drive[3:0], lba_hi, lba_mid, lba_lo}), .arm(arm), .step(step),
    .lba_step(lba_step), .lba_cur(lba_cur), .drq_last(drq_last),
    .cmd_last(cmd_last), .cmd_empty(cmd_empty)
  );

  ata_intr_ctl i_irq (
    .clk(clk), .rst_n(rst_n), .post(post), .clr(clr), .pend(pend), .misuse(misuse)
  );

  assign selected = (drive[DRV_DEV] == DEV_ID);
  assign kind     = classify(acc_wdata[7:0]);
  assign status   = {bsy_q, 1'b1, 1'b0, dsc_q, drq_q, 2'b00, serr_q};

  always_comb begin
    st_d = st_q; bsy_d = bsy_q; drq_d = drq_q; serr_d = serr_q; dsc_d = dsc_q; dir_d = dir_q;
    post = 1'b0; clr = 1'b0; fin = 1'b0; load_cmd = 1'b0; arm = 1'b0;
    step = 1'b0; lba_step = 1'b0; load_max = 1'b0; miss = 1'b0;
    case (st_q)
      ST_IDLE_NS: if (selected) st_d = ST_IDLE_S;
      ST_IDLE_S, ST_IDLE_SI: begin
        if (!selected) begin
          st_d = ST_IDLE_NS;
          clr  = (st_q == ST_IDLE_SI);
        end else if (st_q == ST_IDLE_SI && (ev.stat_rd || nien)) begin
          st_d = ST_IDLE_S;
          clr  = 1'b1;
        end else if (ev.cmd_wr) begin
          clr    = (st_q == ST_IDLE_SI);
          serr_d = 1'b0;
          dsc_d  = 1'b0;
          bsy_d  = 1'b1;
          drq_d  = 1'b0;
          case (kind)
            CK_NODATA:  fin = 1'b1;
            CK_MAXADDR: begin fin = 1'b1; load_max = 1'b1; end
            CK_BAD:     begin fin = 1'b1; serr_d = 1'b1; end
            default: begin
              if (!drive[DRV_LBA]) begin
                fin    = 1'b1;
                serr_d = 1'b1;
              end else begin
                load_cmd = 1'b1;
                case (kind)
                  CK_PIO_IN:  st_d = ST_IN_REQ;
                  CK_PIO_OUT: st_d = ST_OUT_PREP;
                  default: begin
                    st_d  = ST_DMA;
                    bsy_d = 1'b0;
                    drq_d = 1'b1;
                    dir_d = (kind == CK_DMA_IN);
                  end
                endcase
              end
            end
          endcase
        end
      end
      ST_IN_REQ: if (req_ready) begin
        lba_step = 1'b1;
        arm      = 1'b1;
        bsy_d    = 1'b0;
        drq_d    = 1'b1;
        if (!nien) begin st_d = ST_IN_INTR; post = 1'b1; end
        else st_d = ST_IN_XFER;
      end
      ST_IN_INTR, ST_OUT_INTR: if (ev.stat_rd) begin
        clr  = 1'b1;
        st_d = (st_q == ST_IN_INTR) ? ST_IN_XFER : ST_OUT_XFER;
      end
      ST_IN_XFER: if (ev.data_rd) begin
        if (!rd_valid) miss = 1'b1;
        else begin
          step = 1'b1;
          if (drq_last) begin
            drq_d = 1'b0;
            if (cmd_last) begin bsy_d = 1'b0; st_d = ST_IDLE_S; end
            else begin bsy_d = 1'b1; st_d = ST_IN_REQ; end
          end
        end
      end
      ST_OUT_PREP: begin
        if (cmd_empty) fin = 1'b1;
        else begin
          arm   = 1'b1;
          bsy_d = 1'b0;
          drq_d = 1'b1;
          if (!nien) begin st_d = ST_OUT_INTR; post = 1'b1; end
          else st_d = ST_OUT_XFER;
        end
      end
      ST_OUT_XFER: if (ev.data_wr) begin
        if (!wr_ready) miss = 1'b1;
        else begin
          step = 1'b1;
          if (drq_last) begin bsy_d = 1'b1; drq_d = 1'b0; st_d = ST_OUT_COMMIT; end
        end
      end
      ST_OUT_COMMIT: if (req_ready) begin
        lba_step = 1'b1;
        st_d     = ST_OUT_PREP;
      end
      ST_DMA: if (dma_done) begin
        fin   = 1'b1;
        dsc_d = 1'b1;
      end
      default: st_d = ST_IDLE_S;
    endcase
    if (fin) begin
      bsy_d = 1'b0;
      drq_d = 1'b0;
      if (!nien) begin st_d = ST_IDLE_SI; post = 1'b1; end
      else st_d = ST_IDLE_S;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= DEV_ID ? ST_IDLE_NS : ST_IDLE_S;
      bsy_q    <= 1'b0;
      drq_q    <= 1'b0;
      serr_q   <= 1'b0;
      dsc_q    <= 1'b0;
      dir_q    <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      st_q     <= st_d;
      bsy_q    <= bsy_d;
      drq_q    <= drq_d;
      serr_q   <= serr_d;
      dsc_q    <= dsc_d;
      dir_q    <= dir_d;
      err_flag <= err_flag | ev.bad | misuse | miss;
    end
  end

  always_comb begin
    if (acc_ctl) acc_rdata = {8'h00, status};
    else begin
      case (acc_addr)
        REG_DATA: acc_rdata = (st_q == ST_IN_XFER) ? rd_data : 16'h0000;
        REG_ERR:  acc_rdata = {13'd0, serr_q, 2'b00};
        3'd2:     acc_rdata = {8'h00, sec_cnt};
        3'd3:     acc_rdata = {8'h00, lba_lo};
        3'd4:     acc_rdata = {8'h00, lba_mid};
        3'd5:     acc_rdata = {8'h00, lba_hi};
        3'd6:     acc_rdata = {8'h00, drive};
        default:  acc_rdata = {8'h00, status};
      endcase
    end
  end

  assign intrq      = pend;
  assign req_valid  = (st_q == ST_IN_REQ) || (st_q == ST_OUT_COMMIT);
  assign req_store  = (st_q == ST_OUT_COMMIT);
  assign req_lba    = lba_cur;
  assign rd_ready   = ev.data_rd && (st_q == ST_IN_XFER) && rd_valid;
  assign wr_valid   = ev.data_wr && (st_q == ST_OUT_XFER);
  assign wr_data    = acc_wdata;
  assign dma_active = (st_q == ST_DMA);
  assign dma_to_mem = dir_q;

endmodule

// File: rtl/ata_dev_chk.sv
module ata_dev_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        intrq,
  input logic        nien,
  input logic        err_flag,
  input logic        bsy,
  input logic        drq,
  input logic        req_valid,
  input logic        req_ready,
  input logic [27:0] req_lba,
  input logic        rd_ready,
  input logic        dma_active
);

  assert_bsy_drq_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bsy && drq));

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_lba)));

  assert_rd_in_drq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> drq);

  assert_intr_needs_nien_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intrq) |-> !$past(nien));

  assert_dma_not_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dma_active |-> (!bsy && drq));

  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

endmodule

bind ata_dev_ctrl ata_dev_chk i_chk (
  .clk(clk), .rst_n(rst_n), .intrq(intrq), .nien(nien), .err_flag(err_flag),
  .bsy(bsy_q), .drq(drq_q), .req_valid(req_valid), .req_ready(req_ready),
  .req_lba(req_lba), .rd_ready(rd_ready), .dma_active(dma_active)
);

// File: tb/test_ata_dev_ctrl.sv
`timescale 1ns/100ps
module test_ata_dev_ctrl;

  localparam int unsigned SW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_stb = 1'b0, acc_wr = 1'b0, acc_ctl = 1'b0, acc_wide = 1'b0;
  logic [2:0]  acc_addr = '0;
  logic [15:0] acc_wdata = '0;
  logic [15:0] acc_rdata;
  logic        intrq, err_flag, req_valid, req_store, rd_ready, wr_valid;
  logic        dma_active, dma_to_mem;
  logic [27:0] req_lba;
  logic [15:0] wr_data, rd_data;
  logic        req_ready = 1'b0;
  logic        dma_done = 1'b0;
  logic [27:0] buf_lba = '0;
  logic [7:0]  buf_idx = '0;

  int n_checks = 0, n_fail = 0, mon_checks = 0, mon_fail = 0;
  logic [31:0] exp_q[$];

  always #2.5 clk = ~clk;

  ata_dev_ctrl #(.SECTOR_WORDS(SW), .CAPACITY(28'h1234567), .DEV_ID(1'b0)) i_ata_dev_ctrl (
    .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .acc_wr(acc_wr), .acc_ctl(acc_ctl),
    .acc_addr(acc_addr), .acc_wide(acc_wide), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .intrq(intrq), .err_flag(err_flag), .req_valid(req_valid), .req_ready(req_ready),
    .req_store(req_store), .req_lba(req_lba), .rd_valid(1'b1), .rd_ready(rd_ready),
    .rd_data(rd_data), .wr_valid(wr_valid), .wr_ready(1'b1), .wr_data(wr_data),
    .dma_active(dma_active), .dma_to_mem(dma_to_mem), .dma_done(dma_done)
  );

  // sector buffer model: accepts a request every other cycle
  assign rd_data = {buf_lba[7:0], buf_idx};
  always @(posedge clk) begin
    if (!rst_n) req_ready <= 1'b0;
    else req_ready <= req_valid & ~req_ready;
    if (req_valid && req_ready && !req_store) begin
      buf_lba <= req_lba;
      buf_idx <= '0;
    end else if (rd_ready) buf_idx <= buf_idx + 8'd1;
  end

  // scoreboard monitor for the outbound stream and commits
  always @(posedge clk) begin
    logic [31:0] got, want;
    if (rst_n && ((wr_valid) || (req_valid && req_ready && req_store))) begin
      got = wr_valid ? {16'h0000, wr_data} : {4'h8, req_lba};
      mon_checks++;
      if (exp_q.size() == 0) begin
        mon_fail++;
        $display("FAIL R9 unexpected output item actual %h expected none", got);
      end else begin
        want = exp_q.pop_front();
        if (got !== want) begin
          mon_fail++;
          $display("FAIL R9 output item actual %h expected %h", got, want);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit ctl, input bit wr, input logic [2:0] a, input bit wide,
                     input logic [15:0] d, output logic [15:0] q);
    @(negedge clk);
    acc_stb = 1'b1; acc_ctl = ctl; acc_wr = wr; acc_addr = a; acc_wide = wide; acc_wdata = d;
    #1 q = acc_rdata;
    @(posedge clk);
    #1 acc_stb = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic wb(input logic [2:0] a, input logic [7:0] d);
    logic [15:0] q;
    acc(1'b0, 1'b1, a, 1'b0, {8'h00, d}, q);
  endtask

  task automatic rb(input logic [2:0] a, output logic [7:0] d);
    logic [15:0] q;
    acc(1'b0, 1'b0, a, 1'b0, 16'h0, q);
    d = q[7:0];
  endtask

  task automatic alt(output logic [7:0] d);
    logic [15:0] q;
    acc(1'b1, 1'b0, 3'd6, 1'b0, 16'h0, q);
    d = q[7:0];
  endtask

  task automatic ctlw(input logic [7:0] d);
    logic [15:0] q;
    acc(1'b1, 1'b1, 3'd6, 1'b0, {8'h00, d}, q);
  endtask

  task automatic wait_drq(output logic [7:0] s);
    for (int i = 0; i < 50; i++) begin
      alt(s);
      if (s[3]) break;
    end
  endtask

  task automatic wait_idle(output logic [7:0] s);
    for (int i = 0; i < 50; i++) begin
      alt(s);
      if (!s[7] && !s[3]) break;
    end
  endtask

  task automatic setup(input logic [7:0] drv, input logic [23:0] lba, input logic [7:0] cnt);
    wb(3'd6, drv); wb(3'd3, lba[7:0]); wb(3'd4, lba[15:8]); wb(3'd5, lba[23:16]); wb(3'd2, cnt);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    $display("FAIL watchdog expired actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_checks + mon_checks + 1, n_fail + mon_fail + 1);
    $finish;
  end

  initial begin
    logic [7:0]  s, v;
    logic [15:0] q;
    int bad_words;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    alt(s);
    chk("R1 reset status", 32'(s), 32'h40);
    chk("R1 reset intrq", 32'(intrq), 0);
    chk("R1 reset err_flag", 32'(err_flag), 0);

    // R2: deselect then issue a command
    wb(3'd6, 8'h50);
    wb(3'd7, 8'hE7);
    alt(s);
    chk("R2 unselected command status", 32'(s), 32'h40);
    chk("R2 unselected command intrq", 32'(intrq), 0);
    wb(3'd6, 8'h40);

    // R3, R4
    ctlw(8'h00);
    wb(3'd7, 8'hE7);
    alt(s);
    chk("R3 non-data status", 32'(s), 32'h40);
    chk("R3 non-data intrq", 32'(intrq), 1);
    alt(s);
    chk("R4 alt status keeps intrq", 32'(intrq), 1);
    rb(3'd7, s);
    chk("R4 primary status value", 32'(s), 32'h40);
    @(posedge clk); #1;
    chk("R4 primary status clears intrq", 32'(intrq), 0);

    // R13
    wb(3'd7, 8'h70);
    chk("R13 interrupt posted", 32'(intrq), 1);
    ctlw(8'h02);
    repeat (2) @(posedge clk); #1;
    chk("R13 nIEN set clears interrupt", 32'(intrq), 0);

    // R5
    wb(3'd7, 8'h10);
    alt(s);
    chk("R5 status with nIEN", 32'(s), 32'h40);
    chk("R5 no interrupt with nIEN", 32'(intrq), 0);

    // R6
    wb(3'd7, 8'hF8);
    rb(3'd3, v); chk("R6 max bits 7:0", 32'(v), 32'h66);
    rb(3'd4, v); chk("R6 max bits 15:8", 32'(v), 32'h45);
    rb(3'd5, v); chk("R6 max bits 23:16", 32'(v), 32'h23);
    rb(3'd6, v); chk("R6 max bits 27:24", 32'(v), 32'h41);

    // R7
    ctlw(8'h00);
    setup(8'h00, 24'h000010, 8'd1);
    wb(3'd7, 8'h20);
    alt(s);
    chk("R7 reject status", 32'(s), 32'h41);
    chk("R7 reject intrq", 32'(intrq), 1);
    rb(3'd1, v);
    chk("R7 error register", 32'(v), 32'h04);
    rb(3'd7, s);

    // R8: two sectors, nIEN clear
    setup(8'h40, 24'h000010, 8'd2);
    wb(3'd7, 8'h20);
    for (int sct = 0; sct < 2; sct++) begin
      wait_drq(s);
      chk("R8 data ready status", 32'(s), 32'h48);
      chk("R8 data ready intrq", 32'(intrq), 1);
      rb(3'd7, s);
      @(posedge clk); #1;
      chk("R8 status read clears intrq", 32'(intrq), 0);
      for (int w = 0; w < SW; w++) begin
        acc(1'b0, 1'b0, 3'd0, 1'b1, 16'h0, q);
        chk("R8 data word", 32'(q), 32'({8'(8'h10 + sct), 8'(w)}));
      end
    end
    alt(s);
    chk("R8 final status", 32'(s), 32'h40);
    chk("R8 no interrupt after last read", 32'(intrq), 0);

    // R9: two sectors with nIEN set
    ctlw(8'h02);
    setup(8'h40, 24'h000020, 8'd2);
    wb(3'd7, 8'h30);
    for (int sct = 0; sct < 2; sct++) begin
      wait_drq(s);
      chk("R9 data request status", 32'(s), 32'h48);
      chk("R9 no interrupt with nIEN", 32'(intrq), 0);
      for (int w = 0; w < SW; w++) begin
        exp_q.push_back({16'h0000, 8'hA0 + 8'(sct), 8'(w)});
        acc(1'b0, 1'b1, 3'd0, 1'b1, {8'hA0 + 8'(sct), 8'(w)}, q);
      end
      exp_q.push_back({4'h8, 28'h20 + 28'(sct)});
    end
    wait_idle(s);
    chk("R9 completion status", 32'(s), 32'h40);
    chk("R9 completion no interrupt", 32'(intrq), 0);

    // R9: one sector with nIEN clear
    ctlw(8'h00);
    setup(8'h40, 24'h000030, 8'd1);
    wb(3'd7, 8'hC5);
    wait_drq(s);
    chk("R9 data request interrupt", 32'(intrq), 1);
    rb(3'd7, s);
    for (int w = 0; w < SW; w++) begin
      exp_q.push_back({16'h0000, 16'h5500 + 16'(w)});
      acc(1'b0, 1'b1, 3'd0, 1'b1, 16'h5500 + 16'(w), q);
    end
    exp_q.push_back({4'h8, 28'h30});
    wait_idle(s);
    chk("R9 completion status nIEN clear", 32'(s), 32'h40);
    chk("R9 completion interrupt", 32'(intrq), 1);
    rb(3'd7, s);
    chk("R9 scoreboard drained", 32'(exp_q.size()), 0);

    // R10: count 0 means 256 sectors
    ctlw(8'h02);
    setup(8'h40, 24'h000100, 8'd0);
    wb(3'd7, 8'hC4);
    bad_words = 0;
    for (int sct = 0; sct < 256; sct++) begin
      wait_drq(s);
      for (int w = 0; w < SW; w++) begin
        acc(1'b0, 1'b0, 3'd0, 1'b1, 16'h0, q);
        if (q !== {8'(sct), 8'(w)}) bad_words++;
      end
    end
    chk("R10 words of 256 sectors", 32'(bad_words), 0);
    alt(s);
    chk("R10 done after 256 sectors", 32'(s), 32'h40);

    // R11: DMA both directions
    ctlw(8'h00);
    setup(8'h40, 24'h000200, 8'd1);
    wb(3'd7, 8'hC8);
    alt(s);
    chk("R11 dma status", 32'(s), 32'h48);
    chk("R11 dma active", 32'(dma_active), 1);
    chk("R11 dma to memory", 32'(dma_to_mem), 1);
    @(negedge clk); dma_done = 1'b1;
    @(negedge clk); dma_done = 1'b0;
    alt(s);
    chk("R11 dma done status", 32'(s), 32'h50);
    chk("R11 dma done interrupt", 32'(intrq), 1);
    rb(3'd7, s);
    wb(3'd7, 8'hCA);
    chk("R11 dma from memory", 32'(dma_to_mem), 0);
    @(negedge clk); dma_done = 1'b1;
    @(negedge clk); dma_done = 1'b0;
    rb(3'd7, s);

    // R12
    chk("R12 no error before illegal access", 32'(err_flag), 0);
    wb(3'd3, 8'h77);
    acc(1'b0, 1'b1, 3'd3, 1'b1, 16'hABCD, q);
    rb(3'd3, v);
    chk("R12 illegal write ignored", 32'(v), 32'h77);
    chk("R12 error flag set", 32'(err_flag), 1);
    alt(s);
    chk("R12 error flag sticky", 32'(err_flag), 1);

    repeat (4) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_checks + mon_checks, n_fail + mon_fail);
    $finish;
  end

endmodule